// File: doc/BRIEF.md
# Three-Wire Transceiver Configuration Sequencer

This block loads the control registers of a half-duplex quadrature IF transceiver through a three-wire synchronous serial link. The link has a serial clock, a serial data line and a latch strobe. The block holds five 20-bit register images. When a start request arrives, it copies all five images from its input bus, in one cycle. It then sends each image most-significant bit first. After the twentieth bit of a word it raises the latch strobe for one serial-clock period. The receiving device uses the two least-significant bits of each word to decide which register the word is written to. The block sends those bits unchanged, as they appear in the image.

The image in slot 0 holds the mode register, and the block always sends it first. Slots 1 to 4 follow in ascending order. These carry the reference divide ratio, the VCO divide coefficients and the DC-offset calibration timing. Two enable pins, together with bit 0 of the mode register, select between transmit and receive. The block changes those pins in the same cycle that the mode word is latched, so that the device never sees a new pin state combined with an old mode. While a sequence runs, `busy` is high. A single-cycle `done` pulse marks the end of the last latch.

Top module: `xcvr_cfg_seq`

## Requirements
- R1: After reset, `sclk`, `sdata`, `latchEn`, `txEn`, `rxEn`, `busy` and `done` are all low.
- R2: Each word is sent as exactly 20 bits, most significant bit first. The bits a receiver samples on the rising edges of `sclk` reproduce the image, including the register-select field in bits 1:0.
- R3: Each sequence sends five words in this order: slot 0 (mode) first, then slots 1, 2, 3 and 4.
- R4: `sdata` changes only while `sclk` is low, and holds one value for the whole high phase of `sclk`.
- R5: `sclk` is high for CLK_DIV system cycles and low for CLK_DIV system cycles, and it toggles only while `busy` is high.
- R6: `latchEn` rises only after 20 rising edges of `sclk` in the current word. It stays high for 2*CLK_DIV cycles, and during that time `sclk` and `sdata` are low.
- R7: `txEn` and `rxEn` keep their previous values until the mode word is latched. In the cycle where `latchEn` first rises, they take the `txReq`/`rxReq` values that were sampled at start.
- R8: `busy` stays high for exactly 5*2*CLK_DIV*21 cycles after start is accepted. Then `done` is high for exactly one cycle, with `busy` low.
- R9: A start request that arrives while `busy` is high is ignored. The words sent and the length of the sequence do not change.
- R10: The images and enable requests are captured when start is accepted. Changes to `cfgWords`, `txReq` or `rxReq` after that have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a configuration sequence |
| cfgWords | input | 100 | Five 20-bit images; slot i is at bits [20*i+19:20*i], slot 0 is the mode word |
| txReq | input | 1 | Requested level of the transmit-enable pin |
| rxReq | input | 1 | Requested level of the receive-enable pin |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |
| latchEn | output | 1 | Latch strobe after each 20-bit word |
| txEn | output | 1 | Transmit-enable pin to the device |
| rxEn | output | 1 | Receive-enable pin to the device |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse after the final latch |

## Verification
All outputs of the block are registered or decoded from registered state, so every result is checked at the falling edge of the system clock that follows the edge producing it.

Timing is counted from the edge that accepts start:
- Each half of a serial-clock period is due exactly CLK_DIV cycles after the previous one.
- The latch strobe is due 40*CLK_DIV cycles after the start of its word.
- `done` is due 210*CLK_DIV cycles after start.

The bench behaves as a 20-bit receiver. It shifts in `sdata` on each observed rising edge of `sclk`, and it checks every high-phase length, latch length and busy length with its own counters against these figures. It does not wait on any fixed delay.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // copy images and enable requests, preload slot 0
    logic loadNext;  // preload image at nextIdx
    logic shift;     // advance to next bit
    logic applyEn;   // drive enable pins (mode word latch)
  } seq_strobe_t;

endpackage

// File: rtl/xcvr_cfg_ctrl.sv
module xcvr_cfg_ctrl
  import xcvr_cfg_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int NUM_REGS = 5,
  parameter int CLK_DIV  = 4,
  parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output seq_strobe_t      strobe,
  output logic [IDX_W-1:0] nextIdx,
  output logic             shiftActive,
  output logic             sclk,
  output logic             latchEn,
  output logic             busy,
  output logic             done
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS - 1);

  seq_state_e       state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] wordIdx;
  logic             hiPhase;
  logic             halfTick;
  logic             halfEnd;

  assign halfTick = (divCnt == DIV_LAST);
  assign halfEnd  = halfTick && hiPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      wordIdx <= '0;
      hiPhase <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) begin
        divCnt <= halfTick ? '0 : divCnt + 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SHIFT;
            divCnt  <= '0;
            bitCnt  <= '0;
            wordIdx <= '0;
            hiPhase <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (halfTick) begin
            hiPhase <= !hiPhase;
            if (hiPhase) begin
              if (bitCnt == BIT_LAST) begin
                state  <= ST_LATCH;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_LATCH: begin
          if (halfTick) begin
            hiPhase <= !hiPhase;
            if (hiPhase) begin
              if (wordIdx == IDX_LAST) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                wordIdx <= wordIdx + 1'b1;
                state   <= ST_SHIFT;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.shift    = (state == ST_SHIFT) && halfEnd && (bitCnt != BIT_LAST);
    strobe.loadNext = (state == ST_LATCH) && halfEnd && (wordIdx != IDX_LAST);
    strobe.applyEn  = (state == ST_SHIFT) && halfEnd && (bitCnt == BIT_LAST)
                      && (wordIdx == '0);
  end

  assign nextIdx     = wordIdx + 1'b1;
  assign shiftActive = (state == ST_SHIFT);
  assign sclk        = (state == ST_SHIFT) && hiPhase;
  assign latchEn     = (state == ST_LATCH);
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/xcvr_cfg_dpath.sv
module xcvr_cfg_dpath
  import xcvr_cfg_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int NUM_REGS = 5,
  parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seq_strobe_t                strobe,
  input  logic [IDX_W-1:0]           nextIdx,
  input  logic                       shiftActive,
  input  logic [NUM_REGS*WORD_W-1:0] cfgWords,
  input  logic                       txReq,
  input  logic                       rxReq,
  output logic                       sdata,
  output logic                       txEn,
  output logic                       rxEn
);

  logic [WORD_W-1:0] images [NUM_REGS];
  logic [WORD_W-1:0] shReg;
  logic              txHold;
  logic              rxHold;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_img
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        images[gi] <= '0;
      end else if (strobe.capture) begin
        images[gi] <= cfgWords[gi*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      txHold <= 1'b0;
      rxHold <= 1'b0;
      txEn   <= 1'b0;
      rxEn   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        shReg  <= cfgWords[WORD_W-1:0];
        txHold <= txReq;
        rxHold <= rxReq;
      end else if (strobe.loadNext) begin
        shReg <= images[nextIdx];
      end else if (strobe.shift) begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
      if (strobe.applyEn) begin
        txEn <= txHold;
        rxEn <= rxHold;
      end
    end
  end

  assign sdata = shiftActive & shReg[WORD_W-1];

endmodule

// File: rtl/xcvr_cfg_seq.sv
module xcvr_cfg_seq
  import xcvr_cfg_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int NUM_REGS = 5,
  parameter int CLK_DIV  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_REGS*WORD_W-1:0] cfgWords,
  input  logic                       txReq,
  input  logic                       rxReq,
  output logic                       sclk,
  output logic                       sdata,
  output logic                       latchEn,
  output logic                       txEn,
  output logic                       rxEn,
  output logic                       busy,
  output logic                       done
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  seq_strobe_t      strobe;
  logic [IDX_W-1:0] nextIdx;
  logic             shiftActive;

  xcvr_cfg_ctrl #(
    .WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .CLK_DIV(CLK_DIV), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe),
    .nextIdx(nextIdx), .shiftActive(shiftActive), .sclk(sclk),
    .latchEn(latchEn), .busy(busy), .done(done)
  );

  xcvr_cfg_dpath #(
    .WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextIdx(nextIdx),
    .shiftActive(shiftActive), .cfgWords(cfgWords), .txReq(txReq),
    .rxReq(rxReq), .sdata(sdata), .txEn(txEn), .rxEn(rxEn)
  );

endmodule

// File: rtl/xcvr_cfg_chk.sv
module xcvr_cfg_chk (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic sdata,
  input logic latchEn,
  input logic txEn,
  input logic rxEn,
  input logic busy,
  input logic done
);

  assert_latch_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> (!sclk && !sdata));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdata));

  assert_link_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk || latchEn) |-> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_pins_at_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((txEn != $past(txEn)) || (rxEn != $past(rxEn))) |-> $rose(latchEn));

endmodule

bind xcvr_cfg_seq xcvr_cfg_chk u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdata(sdata), .latchEn(latchEn),
  .txEn(txEn), .rxEn(rxEn), .busy(busy), .done(done)
);

// File: tb/xcvr_cfg_seq_bench.sv
module xcvr_cfg_seq_bench;

  localparam int W   = 20;
  localparam int N   = 5;
  localparam int DIV = 2;
  localparam int SEQ_LEN = N * 2 * DIV * (W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N*W-1:0] cfgWords = '0;
  logic txReq = 1'b0;
  logic rxReq = 1'b0;
  logic sclk, sdata, latchEn, txEn, rxEn, busy, done;

  always #2.5 clk = ~clk;

  xcvr_cfg_seq #(.WORD_W(W), .NUM_REGS(N), .CLK_DIV(DIV)) u_xcvr_cfg_seq (
    .clk(clk), .rstN(rstN), .start(start), .cfgWords(cfgWords),
    .txReq(txReq), .rxReq(rxReq), .sclk(sclk), .sdata(sdata),
    .latchEn(latchEn), .txEn(txEn), .rxEn(rxEn), .busy(busy), .done(done)
  );

  int testsRun = 0;
  int testsFailed = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected per run
  logic [W-1:0] expWords [N];
  logic [1:0]   oldPins;
  logic [1:0]   newPins;
  int           runsDone = 0;

  // Receiver model
  logic         prevSclk = 1'b0, prevLe = 1'b0, prevBusy = 1'b0, prevDone = 1'b0;
  logic [W-1:0] rxShift = '0;
  logic         riseData = 1'b0;
  bit           holdBad = 1'b0, leBad = 1'b0;
  int rxBits = 0, wordCnt = 0, highCnt = 0, lowCnt = 0, leCnt = 0, busyCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !prevBusy) begin
        wordCnt = 0; rxBits = 0; busyCnt = 0; lowCnt = 0;
      end
      if (busy) busyCnt++;
      if (sclk && !prevSclk) begin
        if (wordCnt > 0 || rxBits > 0)
          check(lowCnt == DIV || (rxBits == 0), "R5 low phase", lowCnt, DIV);
        if (wordCnt == 0 && rxBits == 0)
          check({txEn, rxEn} == oldPins, "R7 pins before mode latch",
                {txEn, rxEn}, oldPins);
        rxShift = {rxShift[W-2:0], sdata};
        rxBits++;
        riseData = sdata;
        highCnt = 0;
        holdBad = 1'b0;
      end
      if (sclk) begin
        highCnt++;
        if (sdata != riseData) holdBad = 1'b1;
      end
      if (!sclk && prevSclk) begin
        check(highCnt == DIV, "R5 high phase", highCnt, DIV);
        check(!holdBad, "R4 data held while sclk high", holdBad, 0);
        lowCnt = 0;
      end
      if (!sclk) lowCnt++;
      if (latchEn && !prevLe) begin
        check(rxBits == W, "R6 bits before latch", rxBits, W);
        if (wordCnt < N)
          check(rxShift == expWords[wordCnt], $sformatf("R2 R3 word slot %0d", wordCnt),
                rxShift, expWords[wordCnt]);
        if (wordCnt == 0)
          check({txEn, rxEn} == newPins, "R7 pins at mode latch",
                {txEn, rxEn}, newPins);
        leCnt = 0;
        leBad = 1'b0;
      end
      if (latchEn) begin
        leCnt++;
        if (sclk || sdata) leBad = 1'b1;
      end
      if (!latchEn && prevLe) begin
        check(leCnt == 2 * DIV, "R6 latch length", leCnt, 2 * DIV);
        check(!leBad, "R6 link quiet during latch", leBad, 0);
        wordCnt++;
        rxBits = 0;
        lowCnt = 0;
      end
      if (prevDone)
        check(!done, "R8 done one cycle", done, 0);
      if (done) begin
        check(!busy, "R8 busy low with done", busy, 0);
        check(busyCnt == SEQ_LEN, "R8 R9 sequence length", busyCnt, SEQ_LEN);
        check(wordCnt == N, "R3 word count", wordCnt, N);
        runsDone++;
      end
      prevSclk = sclk; prevLe = latchEn; prevBusy = busy; prevDone = done;
    end
  end

  task automatic runSeq(input int s);
    logic [W-1:0] w;
    for (int i = 0; i < N; i++) begin
      if (s == 5)      w = '1;
      else if (s == 6) w = 20'hAAAAA;
      else             w = {18'((s * 40503 + i * 4951 + 7) ^ (i << 9)), 2'(i % 4)};
      expWords[i] = w;
      cfgWords[i*W +: W] = w;
    end
    oldPins = {txEn, rxEn};
    newPins = 2'(s);
    @(negedge clk);
    txReq = newPins[1];
    rxReq = newPins[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (s[2]) begin
      // R9 R10: disturb inputs and retry start while busy
      repeat (60) @(negedge clk);
      cfgWords = ~cfgWords;
      txReq = ~txReq;
      rxReq = ~rxReq;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done);
    @(negedge clk);
    @(negedge clk);
    check(!busy && !sclk && !latchEn, "R1 idle after sequence",
          {busy, sclk, latchEn}, 0);
    check({txEn, rxEn} == newPins, "R10 pins hold captured request",
          {txEn, rxEn}, newPins);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    check({sclk, sdata, latchEn, txEn, rxEn, busy, done} == '0, "R1 reset state",
          {sclk, sdata, latchEn, txEn, rxEn, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({sclk, sdata, latchEn, busy, done} == '0, "R1 after reset release",
          {sclk, sdata, latchEn, busy, done}, 0);
    for (int s = 0; s < 8; s++) runSeq(s);
    check(runsDone == 8, "R8 done per run", runsDone, 8);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule